// File: doc/BRIEF.md
# Register Stack Frame Remapper

This block translates logical general-register numbers into physical register-file indices for a machine whose procedures each own a private window of stacked registers. The low 32 logical registers are shared by all procedures and pass through unchanged. Logical registers from 32 upward name slots of the active frame. These slots live in a 96-entry rotating region of a 128-entry physical file, and the frame's base offset picks where in that region the window starts.

A call command gives the new frame's local and output counts. The callee's window opens exactly where the caller's output slots start, so arguments left there appear as the callee's first stacked registers and are not copied. The caller's marker is pushed onto a small internal stack. A return pops it, which gives the caller back its window without moving any data.

Any call that would make the live windows exceed the rotating region, or that would exceed the saved-marker stack, is refused and flagged as overflow. A return with nothing saved is flagged as underflow. Spilling to memory is left to other logic.

Top module: `reg_stack_remap`

## Requirements
- R1: A logical index in 0..31 maps to the same physical index, and its illegal flag is 0.
- R2: Logical index 0 raises the zero indication on a read port, and a write to index 0 never asserts `wr_commit`.
- R3: A stacked logical index r (32..127) maps to physical 32 + ((base + r - 32) mod 96), wrapping inside the rotating region.
- R4: A stacked index with r - 32 >= the frame size raises the illegal flag on that port, and an illegal write never asserts `wr_commit`.
- R5: An accepted call sets the new base to (base + locals) mod 96. The new locals count becomes (size - locals) + `call_locals`, and the new size becomes that plus `call_outs`. The caller's first output slot and the callee's logical 32 then name the same physical register.
- R6: A return with at least one saved marker restores the caller's marker exactly.
- R7: A call is refused when the saved locals of all suspended frames, plus the caller's locals, plus the new frame size exceed 96. `ovf_flag` pulses for one cycle and the marker is unchanged.
- R8: A return with no saved marker pulses `unf_flag` for one cycle and leaves the marker unchanged.
- R9: `cur_marker` holds the frame size in bits 6:0, the locals count in bits 13:7, the base in bits 20:14, and zeros above. After reset it is base `RESET_BASE`, with locals 0 and size 0.
- R10: Command encoding: 0 idle, 1 call, 2 return. Code 3 changes no state and raises no flag.
- R11: A call made while `DEPTH` markers are already saved is refused with `ovf_flag`, even when the register region has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Frame command: 0 idle, 1 call, 2 return, 3 no-op |
| call_locals | input | 7 | Locals added by the callee on a call |
| call_outs | input | 7 | Output slots of the callee on a call |
| rd_idx | input | NRD*7 | Logical index per read port |
| rd_phys | output | NRD*7 | Physical index per read port |
| rd_illegal | output | NRD | Index outside the active frame, per read port |
| rd_zero | output | NRD | Read port addresses logical 0 |
| wr_en | input | 1 | Write request |
| wr_idx | input | 7 | Logical index of the write |
| wr_phys | output | 7 | Physical index of the write |
| wr_illegal | output | 1 | Write index outside the active frame |
| wr_commit | output | 1 | Write may go to the register file |
| ovf_flag | output | 1 | One-cycle pulse: call refused |
| unf_flag | output | 1 | One-cycle pulse: return with nothing saved |
| cur_marker | output | 64 | Current frame marker |

## Verification
Index translation is combinational from the registered marker. The bench therefore applies each logical index on the ports and samples the outputs a fraction of a cycle later, within the same clock period. Marker updates and the overflow and underflow pulses come from registers that load on the edge that samples the command. The bench drives a command just after a falling edge and checks the marker and both flags one nanosecond after the next rising edge, before the one-cycle pulses clear. A reset base near the top of the rotating region makes frames wrap during full sweeps of all 128 logical indices on both read ports and the write port.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

    localparam int LREG_W   = 7;
    localparam int PREG_W   = 7;
    localparam int NGLOBAL  = 32;
    localparam int NSTACKED = 96;
    localparam int MARKER_W = 64;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_CALL = 2'd1,
        CMD_RET  = 2'd2,
        CMD_NOP  = 2'd3
    } frame_cmd_e;

    // Packing order is the marker layout: size low, locals, then base.
    typedef struct packed {
        logic [6:0] base;
        logic [6:0] sol;
        logic [6:0] sof;
    } frame_t;

    typedef struct packed {
        logic [PREG_W-1:0] phys;
        logic              illegal;
        logic              is_zero;
    } lane_map_t;

    function automatic lane_map_t remap_lreg(frame_t f, logic [LREG_W-1:0] lidx);
        lane_map_t m;
        logic [7:0] off;
        logic [7:0] pos;
        off = '0;
        pos = '0;
        m.is_zero = (lidx == '0);
        if (lidx < 7'(NGLOBAL)) begin
            m.phys    = lidx;
            m.illegal = 1'b0;
        end else begin
            off = {1'b0, lidx} - 8'(NGLOBAL);
            pos = off + {1'b0, f.base};
            if (pos >= 8'(NSTACKED)) begin
                pos = pos - 8'(NSTACKED);
            end
            m.phys    = pos[6:0] + 7'(NGLOBAL);
            m.illegal = (off >= {1'b0, f.sof});
        end
        return m;
    endfunction

endpackage

// File: rtl/rsr_lane_map.sv
module rsr_lane_map
    import rsr_pkg::*;
(
    input  frame_t            frame,
    input  logic [LREG_W-1:0] lidx,
    output logic [PREG_W-1:0] phys,
    output logic              illegal,
    output logic              is_zero
);
    lane_map_t m;

    always_comb begin
        m       = remap_lreg(frame, lidx);
        phys    = m.phys;
        illegal = m.illegal;
        is_zero = m.is_zero;
    end
endmodule

// File: rtl/rsr_frame_ctrl.sv
module rsr_frame_ctrl
    import rsr_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int RESET_BASE = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  frame_cmd_e cmd,
    input  logic [6:0] call_locals,
    input  logic [6:0] call_outs,
    output frame_t     cur,
    output logic       ovf,
    output logic       unf
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int DEP_W = $clog2(DEPTH + 1);

    frame_t             saved_q [DEPTH];
    logic [DEP_W-1:0]   depth_q;
    logic [7:0]         used_q;

    logic [IDX_W-1:0]   push_idx;
    logic [IDX_W-1:0]   pop_idx;
    logic [7:0]         in_cnt;
    logic [8:0]         sol_n;
    logic [8:0]         sof_n;
    logic [9:0]         need;
    logic [7:0]         base_sum;
    logic [6:0]         base_n;
    logic               stack_full;
    logic               stack_empty;
    logic               call_ok;
    logic               ret_ok;
    frame_t             callee;
    frame_t             popped;

    always_comb begin
        push_idx    = depth_q[IDX_W-1:0];
        pop_idx     = push_idx - IDX_W'(1);
        popped      = saved_q[pop_idx];
        in_cnt      = {1'b0, cur.sof} - {1'b0, cur.sol};
        sol_n       = {1'b0, in_cnt} + {2'b0, call_locals};
        sof_n       = sol_n + {2'b0, call_outs};
        need        = {2'b0, used_q} + {3'b0, cur.sol} + {1'b0, sof_n};
        base_sum    = {1'b0, cur.base} + {1'b0, cur.sol};
        base_n      = (base_sum >= 8'(NSTACKED)) ? 7'(base_sum - 8'(NSTACKED))
                                                 : base_sum[6:0];
        stack_full  = (depth_q == DEP_W'(DEPTH));
        stack_empty = (depth_q == '0);
        call_ok     = (cmd == CMD_CALL) && !stack_full && (need <= 10'(NSTACKED));
        ret_ok      = (cmd == CMD_RET) && !stack_empty;
        callee.base = base_n;
        callee.sol  = sol_n[6:0];
        callee.sof  = sof_n[6:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '{base: 7'(RESET_BASE), sol: 7'd0, sof: 7'd0};
            depth_q  <= '0;
            used_q   <= '0;
            ovf      <= 1'b0;
            unf      <= 1'b0;
        end else begin
            ovf <= (cmd == CMD_CALL) && !call_ok;
            unf <= (cmd == CMD_RET) && stack_empty;
            if (call_ok) begin
                cur     <= callee;
                depth_q <= depth_q + DEP_W'(1);
                used_q  <= used_q + {1'b0, cur.sol};
            end else if (ret_ok) begin
                cur     <= popped;
                depth_q <= depth_q - DEP_W'(1);
                used_q  <= used_q - {1'b0, popped.sol};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (call_ok) begin
            saved_q[push_idx] <= cur;
        end
    end
endmodule

// File: rtl/reg_stack_remap.sv
module reg_stack_remap
    import rsr_pkg::*;
#(
    parameter int NRD        = 2,
    parameter int DEPTH      = 8,
    parameter int RESET_BASE = 0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [1:0]                 cmd,
    input  logic [6:0]                 call_locals,
    input  logic [6:0]                 call_outs,
    input  logic [NRD-1:0][LREG_W-1:0] rd_idx,
    output logic [NRD-1:0][PREG_W-1:0] rd_phys,
    output logic [NRD-1:0]             rd_illegal,
    output logic [NRD-1:0]             rd_zero,
    input  logic                       wr_en,
    input  logic [LREG_W-1:0]          wr_idx,
    output logic [PREG_W-1:0]          wr_phys,
    output logic                       wr_illegal,
    output logic                       wr_commit,
    output logic                       ovf_flag,
    output logic                       unf_flag,
    output logic [MARKER_W-1:0]        cur_marker
);
    frame_t cur;
    logic   wr_zero;

    rsr_frame_ctrl #(
        .DEPTH      (DEPTH),
        .RESET_BASE (RESET_BASE)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cmd         (frame_cmd_e'(cmd)),
        .call_locals (call_locals),
        .call_outs   (call_outs),
        .cur         (cur),
        .ovf         (ovf_flag),
        .unf         (unf_flag)
    );

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        rsr_lane_map u_map (
            .frame   (cur),
            .lidx    (rd_idx[i]),
            .phys    (rd_phys[i]),
            .illegal (rd_illegal[i]),
            .is_zero (rd_zero[i])
        );
    end

    rsr_lane_map u_wr_map (
        .frame   (cur),
        .lidx    (wr_idx),
        .phys    (wr_phys),
        .illegal (wr_illegal),
        .is_zero (wr_zero)
    );

    assign wr_commit  = wr_en && !wr_illegal && !wr_zero;
    assign cur_marker = {{(MARKER_W - $bits(frame_t)){1'b0}}, cur};
endmodule

// File: rtl/rsr_checker.sv
module rsr_checker #(
    parameter int NRD = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [1:0]           cmd,
    input logic [NRD-1:0][6:0]  rd_idx,
    input logic [NRD-1:0][6:0]  rd_phys,
    input logic [NRD-1:0]       rd_illegal,
    input logic [6:0]           wr_idx,
    input logic                 wr_illegal,
    input logic                 wr_commit,
    input logic                 ovf_flag,
    input logic                 unf_flag,
    input logic [63:0]          cur_marker
);
    logic [7:0] nb_sum;
    logic [6:0] nb_exp;

    always_comb begin
        nb_sum = {1'b0, cur_marker[20:14]} + {1'b0, cur_marker[13:7]};
        nb_exp = (nb_sum >= 8'd96) ? 7'(nb_sum - 8'd96) : nb_sum[6:0];
    end

    for (genvar i = 0; i < NRD; i++) begin : g_port
        // R1
        a_r1_global_identity: assert property (@(posedge clk) disable iff (rst)
            (rd_idx[i] < 7'd32) |-> (rd_phys[i] == rd_idx[i] && !rd_illegal[i]));
        // R3
        a_r3_stacked_region: assert property (@(posedge clk) disable iff (rst)
            (rd_idx[i] >= 7'd32) |-> (rd_phys[i] >= 7'd32));
    end

    a_r2_zero_no_write: assert property (@(posedge clk) disable iff (rst)
        (wr_idx == 7'd0) |-> !wr_commit);

    a_r4_illegal_no_write: assert property (@(posedge clk) disable iff (rst)
        wr_illegal |-> !wr_commit);

    a_r5_call_base: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'd1) |=> (ovf_flag || cur_marker[20:14] == $past(nb_exp)));

    a_r7_ovf_keeps_marker: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |-> $stable(cur_marker));

    a_r8_unf_keeps_marker: assert property (@(posedge clk) disable iff (rst)
        unf_flag |-> $stable(cur_marker));

    a_r10_nop_inert: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'd3) |=> ($stable(cur_marker) && !ovf_flag && !unf_flag));

    a_r9_marker_upper_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> (cur_marker[63:21] == '0));
endmodule

bind reg_stack_remap rsr_checker #(.NRD(NRD)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .rd_idx     (rd_idx),
    .rd_phys    (rd_phys),
    .rd_illegal (rd_illegal),
    .wr_idx     (wr_idx),
    .wr_illegal (wr_illegal),
    .wr_commit  (wr_commit),
    .ovf_flag   (ovf_flag),
    .unf_flag   (unf_flag),
    .cur_marker (cur_marker)
);

// File: tb/tb_reg_stack_remap.sv
`timescale 1ns/100ps
module tb_reg_stack_remap;
    localparam int NRD   = 2;
    localparam int DEPTH = 8;
    localparam int RBASE = 70;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [1:0]           cmd = 2'd0;
    logic [6:0]           call_locals = '0;
    logic [6:0]           call_outs = '0;
    logic [NRD-1:0][6:0]  rd_idx = '0;
    logic [NRD-1:0][6:0]  rd_phys;
    logic [NRD-1:0]       rd_illegal;
    logic [NRD-1:0]       rd_zero;
    logic                 wr_en = 1'b0;
    logic [6:0]           wr_idx = '0;
    logic [6:0]           wr_phys;
    logic                 wr_illegal;
    logic                 wr_commit;
    logic                 ovf_flag;
    logic                 unf_flag;
    logic [63:0]          cur_marker;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int m_base, m_sol, m_sof, m_depth, m_used;
    int s_base [DEPTH];
    int s_sol  [DEPTH];
    int s_sof  [DEPTH];

    always #2 clk = ~clk;

    reg_stack_remap #(.NRD(NRD), .DEPTH(DEPTH), .RESET_BASE(RBASE)) dut (
        .clk(clk), .rst(rst), .cmd(cmd), .call_locals(call_locals), .call_outs(call_outs),
        .rd_idx(rd_idx), .rd_phys(rd_phys), .rd_illegal(rd_illegal), .rd_zero(rd_zero),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_phys(wr_phys), .wr_illegal(wr_illegal),
        .wr_commit(wr_commit), .ovf_flag(ovf_flag), .unf_flag(unf_flag),
        .cur_marker(cur_marker)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void exp_map(int l, output int p, output bit ill);
        if (l < 32) begin
            p = l; ill = 1'b0;
        end else begin
            p   = 32 + ((m_base + l - 32) % 96);
            ill = (l - 32) >= m_sof;
        end
    endfunction

    task automatic check_marker(string req);
        logic [63:0] e;
        e = {43'd0, 7'(m_base), 7'(m_sol), 7'(m_sof)};
        chk(cur_marker == e, req, "marker", longint'(cur_marker), longint'(e));
    endtask

    task automatic sweep();
        for (int l = 0; l < 128; l++) begin
            int p0, p1;
            bit i0, i1;
            string rq;
            rd_idx[0] = 7'(l);
            rd_idx[1] = 7'(127 - l);
            wr_idx    = 7'(l);
            wr_en     = 1'b1;
            #1;
            exp_map(l, p0, i0);
            exp_map(127 - l, p1, i1);
            rq = (l == 0) ? "R2" : (l < 32) ? "R1" : i0 ? "R4" : "R3";
            chk(rd_phys[0] == 7'(p0) && rd_illegal[0] == i0, rq, "rd0 phys/illegal",
                longint'({rd_phys[0], rd_illegal[0]}), longint'({7'(p0), i0}));
            chk(rd_phys[1] == 7'(p1) && rd_illegal[1] == i1, "R3", "rd1 phys/illegal",
                longint'({rd_phys[1], rd_illegal[1]}), longint'({7'(p1), i1}));
            chk(wr_phys == 7'(p0) && wr_illegal == i0, rq, "wr phys/illegal",
                longint'({wr_phys, wr_illegal}), longint'({7'(p0), i0}));
            chk(rd_zero[0] == (l == 0), "R2", "rd zero", longint'(rd_zero[0]), longint'(l == 0));
            chk(wr_commit == (l != 0 && !i0), (l == 0) ? "R2" : "R4", "wr commit",
                longint'(wr_commit), longint'(l != 0 && !i0));
        end
        wr_en = 1'b0;
    endtask

    task automatic do_call(int loc, int outs, string req_ovf);
        int in_c, nsol, nsof, need;
        bit e_ovf;
        in_c = m_sof - m_sol;
        nsol = in_c + loc;
        nsof = nsol + outs;
        need = m_used + m_sol + nsof;
        e_ovf = (m_depth == DEPTH) || (need > 96);
        @(negedge clk);
        cmd = 2'd1; call_locals = 7'(loc); call_outs = 7'(outs);
        @(posedge clk); #1;
        cmd = 2'd0;
        chk(ovf_flag == e_ovf, req_ovf, "ovf flag", longint'(ovf_flag), longint'(e_ovf));
        chk(unf_flag == 1'b0, "R8", "unf on call", longint'(unf_flag), 0);
        if (!e_ovf) begin
            s_base[m_depth] = m_base; s_sol[m_depth] = m_sol; s_sof[m_depth] = m_sof;
            m_depth++;
            m_used += m_sol;
            m_base = (m_base + m_sol) % 96;
            m_sol  = nsol;
            m_sof  = nsof;
        end
        check_marker(e_ovf ? req_ovf : "R5");
    endtask

    task automatic do_ret();
        bit e_unf;
        e_unf = (m_depth == 0);
        @(negedge clk);
        cmd = 2'd2;
        @(posedge clk); #1;
        cmd = 2'd0;
        chk(unf_flag == e_unf, "R8", "unf flag", longint'(unf_flag), longint'(e_unf));
        chk(ovf_flag == 1'b0, "R7", "ovf on return", longint'(ovf_flag), 0);
        if (!e_unf) begin
            m_depth--;
            m_base = s_base[m_depth]; m_sol = s_sol[m_depth]; m_sof = s_sof[m_depth];
            m_used -= m_sol;
        end
        check_marker(e_unf ? "R8" : "R6");
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int p_caller;
        m_base = RBASE; m_sol = 0; m_sof = 0; m_depth = 0; m_used = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check_marker("R9");
        chk(ovf_flag == 0 && unf_flag == 0, "R9", "flags after reset",
            longint'({ovf_flag, unf_flag}), 0);
        sweep();

        do_ret();                 // R8 empty stack
        do_call(5, 3, "R7");      // base 70, sol 5, sof 8
        sweep();

        rd_idx[0] = 7'd37;        // caller's first output slot
        #1 p_caller = int'(rd_phys[0]);
        do_call(4, 2, "R7");      // base 75, sol 7, sof 9
        rd_idx[0] = 7'd32;
        #1 chk(int'(rd_phys[0]) == p_caller, "R5", "outputs become callee inputs",
               longint'(rd_phys[0]), longint'(p_caller));
        sweep();

        @(negedge clk); cmd = 2'd3; call_locals = 7'd9; call_outs = 7'd9;
        @(posedge clk); #1 cmd = 2'd0;
        chk(ovf_flag == 0 && unf_flag == 0, "R10", "nop flags",
            longint'({ovf_flag, unf_flag}), 0);
        check_marker("R10");

        do_call(60, 30, "R7");    // need 104: refused
        do_call(50, 30, "R7");    // base 82, wraps in sweep
        sweep();
        do_call(0, 0, "R7");
        do_call(0, 0, "R7");
        sweep();
        for (int k = 0; k < 3; k++) do_call(0, 0, "R11");
        do_call(0, 0, "R11");     // stack full: refused
        for (int k = 0; k < DEPTH; k++) do_ret();
        sweep();
        do_ret();                 // R8 again

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule